// File: doc/BRIEF.md
# SHA-256 Sigma Instruction Unit

This block is an execution unit for a RISC-V style integer pipeline. It takes a 32-bit instruction word together with the value already read for the first source register. When the word is one of the four SHA-256 sigma/sum instructions, the unit computes the matching transform of the low 32 bits of the operand. The unit then sign-extends the 32-bit result to the register width and presents it one cycle later with the destination register index.

If the hash extension is switched off, a matching word does not execute and the unit raises an illegal-instruction flag instead. Words that are not one of the four encodings are ignored, because another unit owns them. The register width is a parameter and may be 32 or 64.

Top module: `sigma_unit`

## Requirements
- R1: For selector 00000, the result is rotr(x,2) ^ rotr(x,13) ^ rotr(x,22), where x is srcVal[31:0].
- R2: For selector 00001, the result is rotr(x,6) ^ rotr(x,11) ^ rotr(x,25).
- R3: For selector 00010, the result is rotr(x,7) ^ rotr(x,18) ^ (x >> 3), where >> is a logical shift.
- R4: For selector 00011, the result is rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R5: A word matches only when all of these hold: bits 6:0 equal 0010011, bits 14:12 equal 001, bits 31:25 equal 0001000, and the selector in bits 24:20 is one of 00000 to 00011.
- R6: The 32-bit result is sign-extended from its bit 31 to XLEN bits. Operand bits above bit 31 have no effect on the result.
- R7: A valid matching word with extEnable low gives outIllegal=1 and outValid=0 in the next cycle.
- R8: A valid word that does not match, or any word presented with inValid low, gives outValid=0 and outIllegal=0 in the next cycle.
- R9: A valid matching word with extEnable high gives outValid=1 in the next cycle, with the result and with outRd equal to bits 11:7 of the word.
- R10: While rst is high at a clock edge, outValid and outIllegal are 0 after that edge.
- R11: outValid and outIllegal are never high together. outResult holds its value in every cycle that follows a cycle with no execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The instruction word and operand are valid |
| instr | input | 32 | Instruction word |
| srcVal | input | XLEN | Value of the first source register |
| extEnable | input | 1 | Hash extension enabled |
| outValid | output | 1 | Registered result is valid |
| outIllegal | output | 1 | Registered illegal-instruction flag |
| outRd | output | 5 | Destination register index |
| outResult | output | XLEN | Sign-extended result |

## Verification
The bench builds two instances side by side, one with XLEN=64 and one with XLEN=32, and drives both with the same stimulus. The 64-bit build makes the sign-extension into the upper word observable, and shows that random upper operand bits have no effect. The 32-bit build covers the variant in which no extension logic is generated. Corner operands 0, 0xFFFFFFFF and 0x80000000 are applied alongside random values, together with near-miss encodings in each field of the instruction word.

// File: rtl/sha_sig_pkg.sv
package sha_sig_pkg;

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [2:0] FN3_SIG   = 3'b001;
  localparam logic [6:0] FN7_SIG   = 7'b0001000;
  localparam int         NUM_OPS   = 4;

  typedef enum logic [1:0] {
    OP_SUM0 = 2'd0,
    OP_SUM1 = 2'd1,
    OP_SIG0 = 2'd2,
    OP_SIG1 = 2'd3
  } sigOpE;

  typedef struct packed {
    logic  load;
    sigOpE op;
  } dpCtrlT;

  // per-op constants, indexed by the selector value
  localparam int ROT_A [NUM_OPS] = '{2, 6, 7, 17};
  localparam int ROT_B [NUM_OPS] = '{13, 11, 18, 19};
  localparam int AMT_C [NUM_OPS] = '{22, 25, 3, 10};
  localparam bit SHR_C [NUM_OPS] = '{1'b0, 1'b0, 1'b1, 1'b1};

  function automatic logic [31:0] rotr32(logic [31:0] v, int n);
    return (v >> n) | (v << (32 - n));
  endfunction

endpackage

// File: rtl/sigma_ctrl.sv
module sigma_ctrl
  import sha_sig_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] instr,
  input  logic        extEnable,
  output dpCtrlT      dpCtrl,
  output logic        outValid,
  output logic        outIllegal,
  output logic [4:0]  outRd
);

  logic isMatch;
  logic execNow;
  logic trapNow;
  logic unusedRs1Field;

  // the rs1 field is consumed by the register file, not here
  assign unusedRs1Field = ^instr[19:15];

  assign isMatch = (instr[6:0] == OPC_IMM) &&
                   (instr[14:12] == FN3_SIG) &&
                   (instr[31:25] == FN7_SIG) &&
                   (instr[24:22] == 3'b000);

  assign execNow = inValid && isMatch && extEnable;
  assign trapNow = inValid && isMatch && !extEnable;

  assign dpCtrl.load = execNow;
  assign dpCtrl.op   = sigOpE'(instr[21:20]);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= execNow;
      outIllegal <= trapNow;
    end
    if (execNow) outRd <= instr[11:7];
  end

  // R11: the two flags are exclusive
  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outIllegal));

  // R9: a result is only reported after an enabled valid input
  p_valid_cause_r9: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && extEnable));

  // R7: illegal is only reported while the extension was off
  p_illegal_cause_r7: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> $past(inValid && !extEnable));

  // R8: foreign words leave both flags low
  p_foreign_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isMatch) |=> !(outValid || outIllegal));

  // R10: reset clears the flags
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!outValid && !outIllegal));

endmodule

// File: rtl/sigma_dp.sv
module sigma_dp
  import sha_sig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] srcVal,
  input  dpCtrlT          dpCtrl,
  output logic [XLEN-1:0] outResult
);

  localparam int EXT_BITS = XLEN - 32;

  logic [31:0]      xIn;
  logic [31:0]      cand [NUM_OPS];
  logic [31:0]      picked;
  logic [XLEN-1:0]  widened;

  assign xIn = srcVal[31:0];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic [31:0] termC;
    if (SHR_C[g]) begin : g_shr
      assign termC = xIn >> AMT_C[g];
    end else begin : g_rot
      assign termC = rotr32(xIn, AMT_C[g]);
    end
    assign cand[g] = rotr32(xIn, ROT_A[g]) ^ rotr32(xIn, ROT_B[g]) ^ termC;
  end

  assign picked = cand[dpCtrl.op];

  if (EXT_BITS > 0) begin : g_wide
    logic unusedHigh;
    assign unusedHigh = ^srcVal[XLEN-1:32];
    assign widened = {{EXT_BITS{picked[31]}}, picked};

    // R6: the upper word is a copy of bit 31
    p_sign_extend_r6: assert property (@(posedge clk) disable iff (rst)
      $past(dpCtrl.load) |->
        (outResult[XLEN-1:32] == {EXT_BITS{outResult[31]}}));
  end else begin : g_narrow
    assign widened = picked;
  end

  always_ff @(posedge clk) begin
    if (dpCtrl.load) outResult <= widened;
  end

  // R11: the result register holds when nothing executes
  p_hold_result_r11: assert property (@(posedge clk) disable iff (rst)
    !dpCtrl.load |=> $stable(outResult));

  // R1: every transform maps zero to zero
  p_zero_map_r1: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.load && xIn == 32'd0) |=> (outResult == '0));

endmodule

// File: rtl/sigma_unit.sv
module sigma_unit
  import sha_sig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] srcVal,
  input  logic            extEnable,
  output logic            outValid,
  output logic            outIllegal,
  output logic [4:0]      outRd,
  output logic [XLEN-1:0] outResult
);

  dpCtrlT dpCtrl;

  initial begin
    assert (XLEN == 32 || XLEN == 64) else $error("XLEN must be 32 or 64");
  end

  sigma_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .instr      (instr),
    .extEnable  (extEnable),
    .dpCtrl     (dpCtrl),
    .outValid   (outValid),
    .outIllegal (outIllegal),
    .outRd      (outRd)
  );

  sigma_dp #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .srcVal    (srcVal),
    .dpCtrl    (dpCtrl),
    .outResult (outResult)
  );

endmodule

// File: tb/test_sigma_unit.sv
module test_sigma_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] instr;
  logic [63:0] srcVal;
  logic        extEnable;

  logic        v64, ill64, v32, ill32;
  logic [4:0]  rd64, rd32;
  logic [63:0] res64;
  logic [31:0] res32;

  int checks = 0;
  int failures = 0;

  // expected state, tracked behaviourally
  logic        expValid, expIllegal;
  logic [4:0]  expRd;
  logic [31:0] expRes;
  bit          resKnown = 0;

  always #4 clk = ~clk;

  sigma_unit #(.XLEN(64)) i_sigma_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr), .srcVal(srcVal),
    .extEnable(extEnable), .outValid(v64), .outIllegal(ill64),
    .outRd(rd64), .outResult(res64));

  sigma_unit #(.XLEN(32)) i_sigma_unit_w32 (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr), .srcVal(srcVal[31:0]),
    .extEnable(extEnable), .outValid(v32), .outIllegal(ill32),
    .outRd(rd32), .outResult(res32));

  function automatic logic [31:0] rotRight(logic [31:0] v, int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
    return r;
  endfunction

  function automatic logic [31:0] refModel(int sel, logic [31:0] x);
    case (sel)
      0: return rotRight(x, 2) ^ rotRight(x, 13) ^ rotRight(x, 22);
      1: return rotRight(x, 6) ^ rotRight(x, 11) ^ rotRight(x, 25);
      2: return rotRight(x, 7) ^ rotRight(x, 18) ^ (x >> 3);
      default: return rotRight(x, 17) ^ rotRight(x, 19) ^ (x >> 10);
    endcase
  endfunction

  function automatic logic [31:0] mkWord(logic [6:0] f7, logic [4:0] sel,
                                         logic [4:0] rs, logic [2:0] f3,
                                         logic [4:0] rd, logic [6:0] opc);
    return {f7, sel, rs, f3, rd, opc};
  endfunction

  task automatic check1(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    check1(req, "valid64", 64'(v64), 64'(expValid));
    check1(req, "illegal64", 64'(ill64), 64'(expIllegal));
    check1(req, "valid32", 64'(v32), 64'(expValid));
    check1(req, "illegal32", 64'(ill32), 64'(expIllegal));
    if (expValid) begin
      check1(req, "rd64", 64'(rd64), 64'(expRd));
      check1(req, "rd32", 64'(rd32), 64'(expRd));
    end
    if (resKnown) begin
      check1(req, "result64", res64, {{32{expRes[31]}}, expRes});
      check1(req, "result32", 64'(res32), 64'(expRes));
    end
  endtask

  // drive one cycle, predict, then compare after the edge
  task automatic step(string req, logic vld, logic [31:0] w, logic [63:0] s, logic en);
    bit match;
    @(negedge clk);
    inValid = vld; instr = w; srcVal = s; extEnable = en;
    match = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b001) &&
            (w[31:25] == 7'b0001000) && (w[24:22] == 3'b000);
    expValid   = !rst && vld && match && en;
    expIllegal = !rst && vld && match && !en;
    if (vld && match && en) begin
      expRd = w[11:7];
      expRes = refModel(int'(w[21:20]), s[31:0]);
      resKnown = 1;
    end
    @(posedge clk);
    #2;
    compareAll(req);
  endtask

  function automatic logic [31:0] opWord(int sel, logic [4:0] rd);
    return mkWord(7'b0001000, 5'(sel), 5'd9, 3'b001, rd, 7'b0010011);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] corners [3];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000;
    rst = 1; inValid = 0; instr = '0; srcVal = '0; extEnable = 1;
    repeat (3) @(posedge clk);
    // R10: flags clear during reset, even with a valid word offered
    step("R10", 1'b1, opWord(0, 5'd3), 64'h1234, 1'b1);
    @(negedge clk); rst = 0;

    // R1 R2 R3 R4 with corner values, R6 with random upper bits
    for (int sel = 0; sel < 4; sel++) begin
      string tag;
      tag = (sel == 0) ? "R1" : (sel == 1) ? "R2" : (sel == 2) ? "R3" : "R4";
      for (int c = 0; c < 3; c++)
        step(tag, 1'b1, opWord(sel, 5'(c + 1)), {32'h0, corners[c]}, 1'b1);
      for (int k = 0; k < 40; k++)
        step(tag, 1'b1, opWord(sel, 5'($urandom)), {$urandom, $urandom}, 1'b1);
    end

    // R6: upper operand bits ignored; result sign-extended
    step("R6", 1'b1, opWord(2, 5'd7), 64'hDEAD_BEEF_0000_0001, 1'b1);
    step("R6", 1'b1, opWord(2, 5'd7), 64'h0000_0000_0000_0001, 1'b1);
    step("R6", 1'b1, opWord(1, 5'd8), 64'hFFFF_FFFF_8000_0000, 1'b1);

    // R9: back-to-back issue with varying rd, including rd=0 and rd=31
    step("R9", 1'b1, opWord(3, 5'd0), 64'h0F0F_0F0F, 1'b1);
    step("R9", 1'b1, opWord(0, 5'd31), 64'hA5A5_5A5A, 1'b1);

    // R7: extension disabled
    step("R7", 1'b1, opWord(1, 5'd4), 64'h7777_1111, 1'b0);
    step("R7", 1'b1, opWord(3, 5'd5), 64'h1, 1'b0);

    // R8: near misses in every field, and inValid low
    step("R8", 1'b1, mkWord(7'b0001000, 5'b00100, 5'd1, 3'b001, 5'd2, 7'b0010011), 64'h55, 1'b1);
    step("R8", 1'b1, mkWord(7'b0001000, 5'b10000, 5'd1, 3'b001, 5'd2, 7'b0010011), 64'h55, 1'b1);
    step("R8", 1'b1, mkWord(7'b0001001, 5'b00000, 5'd1, 3'b001, 5'd2, 7'b0010011), 64'h55, 1'b1);
    step("R8", 1'b1, mkWord(7'b0001000, 5'b00001, 5'd1, 3'b101, 5'd2, 7'b0010011), 64'h55, 1'b1);
    step("R8", 1'b1, mkWord(7'b0001000, 5'b00010, 5'd1, 3'b001, 5'd2, 7'b0110011), 64'h55, 1'b1);
    step("R8", 1'b0, opWord(0, 5'd6), 64'h99, 1'b1);

    // R11: result holds through idle cycles; the flags stay exclusive
    step("R11", 1'b0, '0, 64'hFFFF, 1'b1);
    step("R11", 1'b1, opWord(2, 5'd9), 64'h0BAD_F00D, 1'b0);

    // R5: all four selectors after a disabled word
    for (int sel = 0; sel < 4; sel++)
      step("R5", 1'b1, opWord(sel, 5'(sel + 10)), 64'hCAFE_BABE_1357_9BDF, 1'b1);

    // R10: reset mid-stream
    @(negedge clk); rst = 1;
    step("R10", 1'b1, opWord(0, 5'd1), 64'h1, 1'b0);
    @(negedge clk); rst = 0;
    step("R10", 1'b0, '0, 64'h0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule